// File: doc/BRIEF.md
# Write-Back Invalidation Snoop Controller

This block controls one small direct-mapped write-back cache that stays coherent with its peers over a shared bus by invalidation. Every line holds one word and is in one of three states: invalid, shared (readable only) or exclusive (readable, writable, dirty, and the only cached copy). The processor side takes read and write requests. Hits are answered at once. Misses go out on the bus as read-miss or write-miss transactions. When a dirty line is displaced, its victim is written back first.

The snoop side watches the read and write misses that other caches place on the bus. When this cache owns the dirty copy of the requested word, it supplies the data and raises an abort, so memory does not answer with a stale value. The owning line then drops to shared on a read miss or to invalid on a write miss. A write miss that hits a shared line invalidates it. Snoops always win over the processor: a processor request that meets a snoop in the same cycle waits one cycle.

There is no clean-exclusive state. The first reader of a word always gets a shared copy, and a write to a shared line is handled as a write miss. Bus arbitration and memory are outside the block. The arbiter answers `bus_req` with `bus_gnt`, and memory returns read-miss data on `bus_fill_valid`/`bus_fill_data`.

Top module: `msi_snoop_ctrl`

## Requirements
- R1: After reset every line is invalid, `cpu_ready`, `bus_req` and `snp_abort` are low, and the first read of any address produces a read miss.
- R2: A read that misses requests the bus with `bus_cmd` = 1 (read miss) and `bus_addr` = the word address. It completes in the cycle the fill arrives, returning the fill data, and the line becomes shared: later reads hit, and a later write is a write miss.
- R3: A write to an invalid or shared line requests the bus with `bus_cmd` = 2 (write miss). It completes only in the cycle `bus_gnt` is high, and the line then holds the written word as exclusive.
- R4: A read hit in shared or exclusive, and a write hit in exclusive, complete in the cycle the request is presented, with `bus_req` low.
- R5: A miss whose index holds an exclusive line with another tag first issues a write-back (`bus_cmd` = 3) carrying the victim address and data, and after its grant issues the read or write miss for the new address.
- R6: A snooped read miss (`snp_cmd` = 1) matching an exclusive line raises `snp_abort` in that cycle with `snp_data` = the line's word, and the line becomes shared.
- R7: A snooped write miss (`snp_cmd` = 2) matching an exclusive line raises `snp_abort` with the line's word, and the line becomes invalid.
- R8: A snooped write miss matching a shared line leaves `snp_abort` low and makes the line invalid.
- R9: A snoop that matches no valid line, or a snooped read miss on a shared line, leaves `snp_abort` low and does not change the line.
- R10: A processor request presented in a cycle with `snp_valid` high is not completed in that cycle. It is served in a following cycle.
- R11: Once raised, `bus_req` holds `bus_cmd` and `bus_addr` until granted, unless a snoop intervenes. A miss never completes before its grant.
- R12: If a snooped write miss to the same word arrives between the grant of a read miss and its fill, the fill data is still returned to the processor, but the line is not kept: the next read of that word misses again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_req | input | 1 | Processor request valid, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = write, 0 = read |
| cpu_addr | input | ADDR_W | Word address |
| cpu_wdata | input | DATA_W | Write data |
| cpu_ready | output | 1 | Request completes this cycle |
| cpu_rdata | output | DATA_W | Read data, valid with `cpu_ready` |
| bus_req | output | 1 | Request for the shared bus |
| bus_gnt | input | 1 | Bus granted; the transaction takes place this cycle |
| bus_cmd | output | 2 | 0 none, 1 read miss, 2 write miss, 3 write-back |
| bus_addr | output | ADDR_W | Transaction word address |
| bus_wdata | output | DATA_W | Write-back data |
| bus_fill_valid | input | 1 | Read-miss data returned this cycle |
| bus_fill_data | input | DATA_W | Read-miss data |
| snp_valid | input | 1 | A peer's transaction is on the bus |
| snp_cmd | input | 2 | Peer command, 1 read miss, 2 write miss |
| snp_addr | input | ADDR_W | Peer word address |
| snp_abort | output | 1 | This cache supplies the data; memory access aborted |
| snp_data | output | DATA_W | Supplied dirty word, valid with `snp_abort` |

## Verification
The hardest situation to reach is a peer's write miss landing in the narrow window after this cache's read miss has been granted but before its fill returns. Only that window distinguishes a correct controller from one that installs stale data. The bench's bus model can inject the peer's write miss in exactly the cycle it returns the fill, then read the word again to show it misses. A second corner is a processor request colliding with a snoop. The bench presents both in one cycle and checks that completion slips by exactly one cycle. Victim write-back ordering is exercised by alternating writes to two tags that share an index.

// File: rtl/msi_pkg.sv
package msi_pkg;

  typedef enum logic [1:0] {
    LS_INV = 2'd0,
    LS_SHR = 2'd1,
    LS_EXC = 2'd2
  } line_state_e;

  typedef enum logic [1:0] {
    BC_IDLE   = 2'd0,
    BC_RDMISS = 2'd1,
    BC_WRMISS = 2'd2,
    BC_WRBACK = 2'd3
  } bus_cmd_e;

  // State a matching line takes after a peer transaction
  function automatic line_state_e snoop_next(line_state_e cur, logic [1:0] cmd);
    line_state_e nxt;
    nxt = cur;
    if (cmd == BC_WRMISS) nxt = LS_INV;
    else if (cmd == BC_RDMISS && cur == LS_EXC) nxt = LS_SHR;
    return nxt;
  endfunction

  // Whether this cache must hand over its dirty word
  function automatic logic snoop_supplies(line_state_e cur, logic [1:0] cmd);
    return (cur == LS_EXC) && (cmd == BC_RDMISS || cmd == BC_WRMISS);
  endfunction

endpackage

// File: rtl/msi_line_array.sv
module msi_line_array
  import msi_pkg::*;
#(
  parameter int IDX_W  = 3,
  parameter int TAG_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [IDX_W-1:0]  pa_idx,
  output line_state_e       pa_state,
  output logic [TAG_W-1:0]  pa_tag,
  output logic [DATA_W-1:0] pa_data,
  input  logic [IDX_W-1:0]  sn_idx,
  output line_state_e       sn_state,
  output logic [TAG_W-1:0]  sn_tag,
  output logic [DATA_W-1:0] sn_data,
  input  logic              sn_we,
  input  line_state_e       sn_new,
  input  logic              pr_we,
  input  logic [IDX_W-1:0]  pr_idx,
  input  line_state_e       pr_state,
  input  logic [TAG_W-1:0]  pr_tag,
  input  logic [DATA_W-1:0] pr_data
);
  localparam int LINES = 1 << IDX_W;

  line_state_e       st_q  [LINES];
  logic [TAG_W-1:0]  tag_q [LINES];
  logic [DATA_W-1:0] dat_q [LINES];

  assign pa_state = st_q[pa_idx];
  assign pa_tag   = tag_q[pa_idx];
  assign pa_data  = dat_q[pa_idx];
  assign sn_state = st_q[sn_idx];
  assign sn_tag   = tag_q[sn_idx];
  assign sn_data  = dat_q[sn_idx];

  // processor update is applied last so it wins on a shared index
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < LINES; i++) st_q[i] <= LS_INV;
    end else begin
      if (sn_we) st_q[sn_idx] <= sn_new;
      if (pr_we) st_q[pr_idx] <= pr_state;
    end
  end

  always_ff @(posedge clk) begin
    if (pr_we) begin
      tag_q[pr_idx] <= pr_tag;
      dat_q[pr_idx] <= pr_data;
    end
  end
endmodule

// File: rtl/msi_snoop_unit.sv
module msi_snoop_unit
  import msi_pkg::*;
#(
  parameter int TAG_W  = 7,
  parameter int DATA_W = 16
) (
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [TAG_W-1:0]  snp_tag,
  input  line_state_e       ln_state,
  input  logic [TAG_W-1:0]  ln_tag,
  input  logic [DATA_W-1:0] ln_data,
  output logic              upd_we,
  output line_state_e       upd_state,
  output logic              supply,
  output logic [DATA_W-1:0] supply_data
);
  logic match;

  assign match       = snp_valid && (ln_state != LS_INV) && (ln_tag == snp_tag);
  assign upd_state   = snoop_next(ln_state, snp_cmd);
  assign upd_we      = match && (upd_state != ln_state);
  assign supply      = match && snoop_supplies(ln_state, snp_cmd);
  assign supply_data = supply ? ln_data : '0;
endmodule

// File: rtl/msi_proc_fsm.sv
module msi_proc_fsm
  import msi_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cpu_req,
  input  logic                    cpu_we,
  input  logic [ADDR_W-1:0]       cpu_addr,
  input  logic [DATA_W-1:0]       cpu_wdata,
  output logic                    cpu_ready,
  output logic [DATA_W-1:0]       cpu_rdata,
  input  logic                    snp_valid,
  input  logic [1:0]              snp_cmd,
  input  logic [ADDR_W-1:0]       snp_addr,
  output logic [IDX_W-1:0]        ln_idx,
  input  line_state_e             ln_state,
  input  logic [ADDR_W-IDX_W-1:0] ln_tag,
  input  logic [DATA_W-1:0]       ln_data,
  output logic                    bus_req,
  input  logic                    bus_gnt,
  output bus_cmd_e                bus_cmd,
  output logic [ADDR_W-1:0]       bus_addr,
  output logic [DATA_W-1:0]       bus_wdata,
  input  logic                    fill_valid,
  input  logic [DATA_W-1:0]       fill_data,
  output logic                    pr_we,
  output logic [IDX_W-1:0]        pr_idx,
  output line_state_e             pr_state,
  output logic [ADDR_W-IDX_W-1:0] pr_tag,
  output logic [DATA_W-1:0]       pr_data,
  output logic                    ev_wb_grant
);
  localparam int TAG_W = ADDR_W - IDX_W;

  typedef enum logic [1:0] {P_IDLE, P_WBACK, P_MISS, P_FILL} pst_e;

  pst_e              st_q, st_d;
  logic [ADDR_W-1:0] pa_q;
  logic              pwe_q;
  logic [DATA_W-1:0] pwd_q;
  logic              stale_q, stale_d;
  logic              load;
  logic [ADDR_W-1:0] cur_addr;
  logic [TAG_W-1:0]  cur_tag;
  logic              tag_hit;
  logic              kill;

  assign cur_addr = (st_q == P_IDLE) ? cpu_addr : pa_q;
  assign ln_idx   = cur_addr[IDX_W-1:0];
  assign cur_tag  = cur_addr[ADDR_W-1:IDX_W];
  assign tag_hit  = (ln_state != LS_INV) && (ln_tag == cur_tag);
  // peer write miss on the word whose fill is outstanding
  assign kill     = snp_valid && (snp_cmd == BC_WRMISS) && (snp_addr == pa_q);
  assign ev_wb_grant = bus_req && bus_gnt && (bus_cmd == BC_WRBACK);

  always_comb begin
    st_d      = st_q;
    stale_d   = stale_q;
    load      = 1'b0;
    cpu_ready = 1'b0;
    cpu_rdata = '0;
    bus_req   = 1'b0;
    bus_cmd   = BC_IDLE;
    bus_addr  = pa_q;
    bus_wdata = '0;
    pr_we     = 1'b0;
    pr_idx    = ln_idx;
    pr_state  = LS_INV;
    pr_tag    = cur_tag;
    pr_data   = pwd_q;
    case (st_q)
      P_IDLE: begin
        if (cpu_req && !snp_valid) begin
          if (!cpu_we && tag_hit) begin
            cpu_ready = 1'b1;
            cpu_rdata = ln_data;
          end else if (cpu_we && tag_hit && ln_state == LS_EXC) begin
            cpu_ready = 1'b1;
            pr_we     = 1'b1;
            pr_state  = LS_EXC;
            pr_data   = cpu_wdata;
          end else begin
            load = 1'b1;
            st_d = (ln_state == LS_EXC && !tag_hit) ? P_WBACK : P_MISS;
          end
        end
      end
      P_WBACK: begin
        if (ln_state != LS_EXC) begin
          st_d = P_MISS;   // a snoop already took the dirty victim
        end else begin
          bus_req   = 1'b1;
          bus_cmd   = BC_WRBACK;
          bus_addr  = {ln_tag, ln_idx};
          bus_wdata = ln_data;
          if (bus_gnt) begin
            pr_we    = 1'b1;
            pr_state = LS_INV;
            pr_tag   = ln_tag;
            pr_data  = ln_data;
            st_d     = P_MISS;
          end
        end
      end
      P_MISS: begin
        bus_req = 1'b1;
        bus_cmd = pwe_q ? BC_WRMISS : BC_RDMISS;
        if (bus_gnt) begin
          if (pwe_q) begin
            cpu_ready = 1'b1;
            pr_we     = 1'b1;
            pr_state  = LS_EXC;
            st_d      = P_IDLE;
          end else begin
            stale_d = 1'b0;
            st_d    = P_FILL;
          end
        end
      end
      default: begin
        if (kill) stale_d = 1'b1;
        if (fill_valid) begin
          cpu_ready = 1'b1;
          cpu_rdata = fill_data;
          st_d      = P_IDLE;
          if (!(stale_q || kill)) begin
            pr_we    = 1'b1;
            pr_state = LS_SHR;
            pr_data  = fill_data;
          end
        end
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= P_IDLE;
      stale_q <= 1'b0;
      pa_q    <= '0;
      pwe_q   <= 1'b0;
      pwd_q   <= '0;
    end else begin
      st_q    <= st_d;
      stale_q <= stale_d;
      if (load) begin
        pa_q  <= cpu_addr;
        pwe_q <= cpu_we;
        pwd_q <= cpu_wdata;
      end
    end
  end
endmodule

// File: rtl/msi_snoop_ctrl.sv
module msi_snoop_ctrl
  import msi_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int IDX_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic [1:0]        bus_cmd,
  output logic [ADDR_W-1:0] bus_addr,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_fill_valid,
  input  logic [DATA_W-1:0] bus_fill_data,
  input  logic              snp_valid,
  input  logic [1:0]        snp_cmd,
  input  logic [ADDR_W-1:0] snp_addr,
  output logic              snp_abort,
  output logic [DATA_W-1:0] snp_data
);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [IDX_W-1:0]  pa_idx;
  line_state_e       pa_state, sn_state, sn_new, pr_state;
  logic [TAG_W-1:0]  pa_tag, sn_tag, pr_tag;
  logic [DATA_W-1:0] pa_data, sn_data, pr_data;
  logic              sn_we, pr_we;
  logic [IDX_W-1:0]  pr_idx;
  bus_cmd_e          cmd_e;
  logic              ev_wb_grant;

  assign bus_cmd = cmd_e;

  msi_line_array #(.IDX_W(IDX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_lines (
    .clk(clk), .rst_n(rst_n),
    .pa_idx(pa_idx), .pa_state(pa_state), .pa_tag(pa_tag), .pa_data(pa_data),
    .sn_idx(snp_addr[IDX_W-1:0]), .sn_state(sn_state), .sn_tag(sn_tag), .sn_data(sn_data),
    .sn_we(sn_we), .sn_new(sn_new),
    .pr_we(pr_we), .pr_idx(pr_idx), .pr_state(pr_state), .pr_tag(pr_tag), .pr_data(pr_data)
  );

  msi_snoop_unit #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_snoop (
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_tag(snp_addr[ADDR_W-1:IDX_W]),
    .ln_state(sn_state), .ln_tag(sn_tag), .ln_data(sn_data),
    .upd_we(sn_we), .upd_state(sn_new), .supply(snp_abort), .supply_data(snp_data)
  );

  msi_proc_fsm #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fsm (
    .clk(clk), .rst_n(rst_n),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .ln_idx(pa_idx), .ln_state(pa_state), .ln_tag(pa_tag), .ln_data(pa_data),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(cmd_e), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .fill_valid(bus_fill_valid), .fill_data(bus_fill_data),
    .pr_we(pr_we), .pr_idx(pr_idx), .pr_state(pr_state), .pr_tag(pr_tag), .pr_data(pr_data),
    .ev_wb_grant(ev_wb_grant)
  );
endmodule

// File: rtl/msi_snoop_ctrl_chk.sv
module msi_snoop_ctrl_chk #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cpu_req,
  input logic              cpu_we,
  input logic              cpu_ready,
  input logic              bus_req,
  input logic              bus_gnt,
  input logic [1:0]        bus_cmd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_fill_valid,
  input logic              snp_valid,
  input logic [1:0]        snp_cmd,
  input logic              snp_abort,
  input logic              ev_wb_grant
);
  // R6 / R7: data is only supplied in answer to a peer miss
  a_r6_abort_on_peer_miss: assert property (@(posedge clk) disable iff (!rst_n)
    snp_abort |-> (snp_valid && (snp_cmd == 2'd1 || snp_cmd == 2'd2)));

  // R10: a snoop cycle never completes a fresh processor request
  a_r10_snoop_stalls_cpu: assert property (@(posedge clk) disable iff (!rst_n)
    (snp_valid && cpu_req && !bus_req && !bus_fill_valid) |-> !cpu_ready);

  // R11: an ungranted request keeps its command and address
  a_r11_request_held: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_gnt && !snp_valid) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

  // R3: a write that needed the bus finishes only with the grant
  a_r3_write_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
    (cpu_ready && cpu_we && bus_req) |-> bus_gnt);

  // R5: a granted write-back is followed by the miss for the new word
  a_r5_miss_after_wb: assert property (@(posedge clk) disable iff (!rst_n)
    ev_wb_grant |=> (bus_req && (bus_cmd == 2'd1 || bus_cmd == 2'd2)));
endmodule

bind msi_snoop_ctrl msi_snoop_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_ready(cpu_ready),
  .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
  .bus_fill_valid(bus_fill_valid), .snp_valid(snp_valid), .snp_cmd(snp_cmd),
  .snp_abort(snp_abort), .ev_wb_grant(ev_wb_grant)
);

// File: tb/msi_snoop_ctrl_bench.sv
module msi_snoop_ctrl_bench;
  localparam int AW = 10;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          cpu_req, cpu_we;
  logic [AW-1:0] cpu_addr;
  logic [DW-1:0] cpu_wdata;
  logic          cpu_ready;
  logic [DW-1:0] cpu_rdata;
  logic          bus_req, bus_gnt;
  logic [1:0]    bus_cmd;
  logic [AW-1:0] bus_addr;
  logic [DW-1:0] bus_wdata;
  logic          bus_fill_valid;
  logic [DW-1:0] bus_fill_data;
  logic          snp_valid;
  logic [1:0]    snp_cmd;
  logic [AW-1:0] snp_addr;
  logic          snp_abort;
  logic [DW-1:0] snp_data;

  always #4 clk = ~clk;   // 125 MHz

  msi_snoop_ctrl #(.ADDR_W(AW), .IDX_W(3), .DATA_W(DW)) u_msi_snoop_ctrl (
    .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr),
    .cpu_wdata(cpu_wdata), .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_cmd(bus_cmd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_fill_valid(bus_fill_valid), .bus_fill_data(bus_fill_data),
    .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
    .snp_abort(snp_abort), .snp_data(snp_data)
  );

  int n_chk = 0;
  int n_bad = 0;

  logic [DW-1:0] mem [1 << AW];
  logic [1:0]    tx_cmd  [4];
  logic [AW-1:0] tx_addr [4];
  logic [DW-1:0] tx_data [4];
  int            tx_n;
  int            rdy_cyc;
  logic [DW-1:0] got;

  localparam logic [AW-1:0] A_ADR = 10'h005;
  localparam logic [AW-1:0] B_ADR = 10'h00D;   // same index as A_ADR
  localparam logic [AW-1:0] C_ADR = 10'h012;
  localparam logic [AW-1:0] E_ADR = 10'h007;

  task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_eq(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  // one processor access with a granting bus and a memory behind it
  task automatic access(input logic we, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                        input int gdly, input bit snoop_in_fill);
    int cyc = 0;
    int wcnt = 0;
    bit done = 0;
    bit fill_now = 0;
    bit fill_nxt = 0;
    logic [AW-1:0] fill_a = '0;
    tx_n = 0;
    rdy_cyc = -1;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = wd;
    while (!done && cyc < 50) begin
      #1;
      if (bus_req) begin
        if (wcnt >= gdly) bus_gnt = 1'b1;
        else wcnt++;
      end
      bus_fill_valid = fill_now;
      bus_fill_data  = mem[fill_a];
      if (fill_now && snoop_in_fill) begin
        snp_valid = 1'b1; snp_cmd = 2'd2; snp_addr = a;
      end
      #1;
      if (bus_req && bus_gnt) begin
        if (tx_n < 4) begin
          tx_cmd[tx_n] = bus_cmd; tx_addr[tx_n] = bus_addr; tx_data[tx_n] = bus_wdata;
        end
        tx_n++;
        wcnt = 0;
        if (bus_cmd == 2'd3) mem[bus_addr] = bus_wdata;
        if (bus_cmd == 2'd1) begin fill_nxt = 1; fill_a = bus_addr; end
      end
      if (cpu_ready) begin done = 1; got = cpu_rdata; rdy_cyc = cyc; end
      @(negedge clk);
      bus_gnt = 1'b0; bus_fill_valid = 1'b0; snp_valid = 1'b0;
      fill_now = fill_nxt; fill_nxt = 0;
      cyc++;
    end
    cpu_req = 1'b0;
    if (!done) check(0, "R11", "access never completed", cyc, 0);
  endtask

  task automatic snoop(input logic [1:0] c, input logic [AW-1:0] a, input bit exp_ab,
                       input logic [DW-1:0] exp_d, input string req);
    @(negedge clk);
    snp_valid = 1'b1; snp_cmd = c; snp_addr = a;
    #2;
    check_eq(req, "snp_abort", snp_abort, exp_ab);
    if (exp_ab) check_eq(req, "snp_data", snp_data, exp_d);
    if (snp_abort) mem[a] = snp_data;
    @(negedge clk);
    snp_valid = 1'b0;
  endtask

  task automatic expect_hit(input logic [DW-1:0] d, input string req);
    check_eq(req, "hit bus transactions", tx_n, 0);
    check_eq(req, "hit ready cycle", rdy_cyc, 0);
    check_eq(req, "hit read data", got, d);
  endtask

  task automatic t_reset;
    check_eq("R1", "cpu_ready after reset", cpu_ready, 0);
    check_eq("R1", "bus_req after reset", bus_req, 0);
    check_eq("R1", "snp_abort after reset", snp_abort, 0);
  endtask

  task automatic t_read_then_write;
    access(0, A_ADR, 0, 0, 0);                 // R1 R2 read miss
    check_eq("R2", "miss tx count", tx_n, 1);
    check_eq("R2", "miss cmd", tx_cmd[0], 1);
    check_eq("R2", "miss addr", tx_addr[0], A_ADR);
    check_eq("R2", "miss ready cycle", rdy_cyc, 2);
    check_eq("R2", "fill data", got, mem[A_ADR]);
    access(0, A_ADR, 0, 0, 0);                 // R4 shared read hit
    expect_hit(mem[A_ADR], "R4");
    access(1, A_ADR, 16'h1111, 0, 0);          // R3 write to shared
    check_eq("R3", "upgrade tx count", tx_n, 1);
    check_eq("R3", "upgrade cmd", tx_cmd[0], 2);
    check_eq("R3", "upgrade ready cycle", rdy_cyc, 1);
    access(0, A_ADR, 0, 0, 0);
    expect_hit(16'h1111, "R3");
    access(1, A_ADR, 16'h2222, 0, 0);          // R4 exclusive write hit
    check_eq("R4", "write hit tx count", tx_n, 0);
    check_eq("R4", "write hit ready cycle", rdy_cyc, 0);
  endtask

  task automatic t_snoop_owned;
    snoop(2'd1, A_ADR, 1, 16'h2222, "R6");
    access(0, A_ADR, 0, 0, 0);
    expect_hit(16'h2222, "R6");
    access(1, A_ADR, 16'h3333, 0, 0);
    check_eq("R6", "write after downgrade cmd", tx_cmd[0], 2);
    snoop(2'd1, B_ADR, 0, 0, "R9");            // other tag, same index
    snoop(2'd2, A_ADR, 1, 16'h3333, "R7");
    access(0, A_ADR, 0, 0, 0);
    check_eq("R7", "read after invalidate cmd", tx_cmd[0], 1);
    check_eq("R7", "read after invalidate data", got, 16'h3333);
  endtask

  task automatic t_snoop_shared;
    snoop(2'd2, A_ADR, 0, 0, "R8");
    access(0, A_ADR, 0, 0, 0);
    check_eq("R8", "re-read tx count", tx_n, 1);
    check_eq("R8", "re-read cmd", tx_cmd[0], 1);
  endtask

  task automatic t_victim;
    access(1, A_ADR, 16'h4444, 0, 0);
    access(1, B_ADR, 16'h5555, 0, 0);
    check_eq("R5", "write victim tx count", tx_n, 2);
    check_eq("R5", "first is write-back", tx_cmd[0], 3);
    check_eq("R5", "write-back addr", tx_addr[0], A_ADR);
    check_eq("R5", "write-back data", tx_data[0], 16'h4444);
    check_eq("R5", "then write miss", tx_cmd[1], 2);
    check_eq("R5", "write miss addr", tx_addr[1], B_ADR);
    check_eq("R5", "write victim ready cycle", rdy_cyc, 2);
    access(0, A_ADR, 0, 0, 0);
    check_eq("R5", "read victim tx count", tx_n, 2);
    check_eq("R5", "read victim wb data", tx_data[0], 16'h5555);
    check_eq("R5", "then read miss", tx_cmd[1], 1);
    check_eq("R5", "read victim ready cycle", rdy_cyc, 3);
    check_eq("R5", "read victim data", got, 16'h4444);
  endtask

  task automatic t_stall;
    @(negedge clk);
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = A_ADR;
    snp_valid = 1'b1; snp_cmd = 2'd1; snp_addr = C_ADR;
    #2;
    check_eq("R10", "ready during snoop", cpu_ready, 0);
    @(negedge clk);
    snp_valid = 1'b0;
    #2;
    check_eq("R10", "ready after snoop", cpu_ready, 1);
    check_eq("R10", "data after snoop", cpu_rdata, 16'h4444);
    @(negedge clk);
    cpu_req = 1'b0;
  endtask

  task automatic t_shared_read_snoop;
    snoop(2'd1, A_ADR, 0, 0, "R9");
    access(0, A_ADR, 0, 0, 0);
    expect_hit(16'h4444, "R9");
  endtask

  task automatic t_slow_grant;
    access(1, C_ADR, 16'h7777, 3, 0);
    check_eq("R11", "delayed grant tx count", tx_n, 1);
    check_eq("R11", "delayed grant ready cycle", rdy_cyc, 4);
    access(0, C_ADR, 0, 0, 0);
    expect_hit(16'h7777, "R11");
  endtask

  task automatic t_fill_race;
    access(0, E_ADR, 0, 0, 1);
    check_eq("R12", "raced fill data", got, mem[E_ADR]);
    check_eq("R12", "raced fill ready cycle", rdy_cyc, 2);
    access(0, E_ADR, 0, 0, 0);
    check_eq("R12", "re-read tx count", tx_n, 1);
    check_eq("R12", "re-read cmd", tx_cmd[0], 1);
  endtask

  initial begin
    for (int i = 0; i < (1 << AW); i++) mem[i] = DW'(i * 3 + 256);
    rst_n = 1'b0; cpu_req = 0; cpu_we = 0; cpu_addr = '0; cpu_wdata = '0;
    bus_gnt = 0; bus_fill_valid = 0; bus_fill_data = '0;
    snp_valid = 0; snp_cmd = '0; snp_addr = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    #2;
    t_reset;
    t_read_then_write;
    t_snoop_owned;
    t_snoop_shared;
    t_victim;
    t_stall;
    t_shared_read_snoop;
    t_slow_grant;
    t_fill_race;
    repeat (2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 8);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule